// File: doc/BRIEF.md
# One-Second Error Count Registers

This unit gathers line-quality statistics for a 2 Mbit/s framed receiver. It keeps two 14-bit event counters. The fault counter counts frame-alignment bit errors while multiframe alignment is missing. Once multiframe alignment is present, it counts errored CRC-4 blocks instead. The far-end counter counts received E bits that report remote block errors, and it does so only while multiframe alignment holds. Error detection happens upstream. The unit receives one strobe per detected event, a one-second tick and a simple register read request.

Each counter is visible through two 8-bit registers. One register carries the low half of the count and the other carries the high half. Bit 7 of every register always reads as one. A mode input selects how the counters are reported:

- In snapshot mode, every tick copies the running count into a reporting copy, and the count restarts from zero.
- In polling mode, software reads the live count, and each read of the low register starts a new counting period.

In both modes a read of the low register freezes the high half, so a low-then-high pair of reads returns one coherent value.

Top module: `pm_err_regs`

## Requirements
- R1: After synchronous reset, all four registers read 80H, and the read data output holds 80H until the first read.
- R2: The register select is 0 for fault low, 1 for fault high, 2 for far-end low and 3 for far-end high. Bit 7 of the read data is always 1. A low register returns count bits 6:0 in bits 6:0.
- R3: With `mf_aligned` low, the fault counter counts only `fas_err` pulses, and `crc_err` is ignored. With `mf_aligned` high, it counts only `crc_err` pulses, and `fas_err` is ignored.
- R4: The far-end counter counts `ebit_err` pulses only while `mf_aligned` is high. It ignores them otherwise.
- R5: In snapshot mode (`poll_mode` = 0), a `sec_tick` copies each running count into the reporting copy and restarts the counter. An event in the tick cycle counts toward the new period.
- R6: In snapshot mode, reads do not disturb the counters, so repeated reads between ticks return the same value.
- R7: In polling mode (`poll_mode` = 1), a low read returns the live count as it stood before that cycle and restarts the counter. An event in the read cycle counts into the new period. `sec_tick` has no effect in this mode.
- R8: A high read returns count bits 13:7 as captured by the most recent low read of the same counter, or zero if there has been no such read since reset.
- R9: A counter saturates at 3FFFH and does not wrap.
- R10: Read data is registered. It appears on the cycle after `rd_en` and holds unchanged while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_mode | input | 1 | 0: per-second snapshot, 1: clear-on-read polling |
| mf_aligned | input | 1 | Multiframe alignment present |
| fas_err | input | 1 | One frame-alignment bit error |
| crc_err | input | 1 | One errored CRC-4 block |
| ebit_err | input | 1 | One received E bit reporting a far-end error |
| sec_tick | input | 1 | One-second timing pulse |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | Register select |
| rd_data | output | 8 | Registered read data |

## Verification
The following are checked on every cycle:

- Bit 7 of the read data is always set.
- Each running count either stays put or steps by one, except on a clearing event.
- A count with no selected source strobe stays unchanged.
- A tick in snapshot mode, or a low read in polling mode, leaves the count at zero or one.
- A saturated count stays at 3FFFH.
- The read data holds while no read is requested.

Other behaviours can only be shown by the bench's scenarios with known event totals:

- the exact values reported after a tick;
- the freezing of the high half between two reads;
- the fact that ticks are ignored in polling mode;
- the split of the count across the two registers.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int REG_W = 8;
    localparam int FLD_W = REG_W - 1;
    localparam int SEL_W = 2;
    localparam int NCNT  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLT_LO = 2'd0,
        SEL_FLT_HI = 2'd1,
        SEL_FEB_LO = 2'd2,
        SEL_FEB_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic feb;
        logic flt;
    } evt_t;

    function automatic logic sel_is_high(input reg_sel_e s);
        return s[0];
    endfunction

    function automatic logic sel_counter(input reg_sel_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/pm_evt_route.sv
module pm_evt_route
    import pm_pkg::*;
(
    input  logic mf_aligned,
    input  logic fas_err,
    input  logic crc_err,
    input  logic ebit_err,
    output evt_t evt
);
    always_comb begin
        evt.flt = mf_aligned ? crc_err : fas_err;
        evt.feb = mf_aligned & ebit_err;
    end
endmodule

// File: rtl/pm_err_counter.sv
module pm_err_counter #(
    parameter int CNT_W = 14,
    localparam int LO_W = (CNT_W + 1) / 2,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             poll,
    input  logic             tick,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] view,
    output logic [HI_W-1:0]  hold
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q, snap_q, base, run_d;
    logic [HI_W-1:0]  hold_q;
    logic             restart;

    always_comb begin
        restart = poll ? rd_lo : tick;
        base    = restart ? '0 : run_q;
        run_d   = (inc && base != CNT_MAX) ? base + 1'b1 : base;
        view    = poll ? run_q : snap_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            snap_q <= '0;
            hold_q <= '0;
        end else begin
            run_q <= run_d;
            if (!poll && tick)
                snap_q <= run_q;
            if (rd_lo)
                hold_q <= view[CNT_W-1:LO_W];
        end
    end

    assign run_cnt = run_q;
    assign hold    = hold_q;
endmodule

// File: rtl/pm_rd_port.sv
module pm_rd_port
    import pm_pkg::*;
#(
    parameter int CNT_W = 14,
    localparam int LO_W = (CNT_W + 1) / 2,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_addr,
    input  logic [CNT_W-1:0] view [NCNT],
    input  logic [HI_W-1:0]  hold [NCNT],
    output logic [NCNT-1:0]  rd_lo,
    output logic [REG_W-1:0] rd_data
);
    reg_sel_e         sel;
    logic             cidx, is_hi;
    logic [FLD_W-1:0] lo_f, hi_f;

    always_comb begin
        sel   = reg_sel_e'(rd_addr);
        cidx  = sel_counter(sel);
        is_hi = sel_is_high(sel);
        lo_f  = FLD_W'(view[cidx][LO_W-1:0]);
        hi_f  = FLD_W'(hold[cidx]);
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_lo
        assign rd_lo[g] = rd_en && !is_hi && (cidx == 1'(g));
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= {1'b1, {FLD_W{1'b0}}};
        else if (rd_en)
            rd_data <= {1'b1, is_hi ? hi_f : lo_f};
    end
endmodule

// File: rtl/pm_err_regs.sv
module pm_err_regs
    import pm_pkg::*;
#(
    parameter int CNT_W = 14,
    localparam int LO_W = (CNT_W + 1) / 2,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_mode,
    input  logic             mf_aligned,
    input  logic             fas_err,
    input  logic             crc_err,
    input  logic             ebit_err,
    input  logic             sec_tick,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data
);
    evt_t             evt;
    logic [NCNT-1:0]  inc, rd_lo;
    logic [CNT_W-1:0] run_cnt [NCNT];
    logic [CNT_W-1:0] view    [NCNT];
    logic [HI_W-1:0]  hold    [NCNT];

    pm_evt_route u_route (
        .mf_aligned (mf_aligned),
        .fas_err    (fas_err),
        .crc_err    (crc_err),
        .ebit_err   (ebit_err),
        .evt        (evt)
    );

    assign inc = {evt.feb, evt.flt};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        pm_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc     (inc[g]),
            .poll    (poll_mode),
            .tick    (sec_tick),
            .rd_lo   (rd_lo[g]),
            .run_cnt (run_cnt[g]),
            .view    (view[g]),
            .hold    (hold[g])
        );
    end

    pm_rd_port #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .view    (view),
        .hold    (hold),
        .rd_lo   (rd_lo),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pm_err_regs_chk.sv
module pm_err_regs_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             poll_mode,
    input logic             mf_aligned,
    input logic             fas_err,
    input logic             crc_err,
    input logic             ebit_err,
    input logic             sec_tick,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] flt_cnt,
    input logic [CNT_W-1:0] feb_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic flt_clr, feb_clr, flt_src, feb_src;

    always_comb begin
        flt_clr = poll_mode ? (rd_en && rd_addr == 2'd0) : sec_tick;
        feb_clr = poll_mode ? (rd_en && rd_addr == 2'd2) : sec_tick;
        flt_src = mf_aligned ? crc_err : fas_err;
        feb_src = mf_aligned && ebit_err;
    end

    p_hdr_bit_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7]);

    p_flt_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!flt_clr && !flt_src) |=> $stable(flt_cnt));

    p_flt_step_r3: assert property (@(posedge clk) disable iff (rst)
        !flt_clr |=> (flt_cnt == $past(flt_cnt)) || (flt_cnt == $past(flt_cnt) + 1'b1));

    p_feb_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!feb_clr && !feb_src) |=> $stable(feb_cnt));

    p_tick_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (!poll_mode && sec_tick) |=> (flt_cnt <= 1) && (feb_cnt <= 1));

    p_poll_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (poll_mode && rd_en && rd_addr == 2'd0) |=> flt_cnt <= 1);

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (flt_cnt == TOP && !flt_clr) |=> flt_cnt == TOP);

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind pm_err_regs pm_err_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .poll_mode  (poll_mode),
    .mf_aligned (mf_aligned),
    .fas_err    (fas_err),
    .crc_err    (crc_err),
    .ebit_err   (ebit_err),
    .sec_tick   (sec_tick),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .flt_cnt    (run_cnt[0]),
    .feb_cnt    (run_cnt[1])
);

// File: tb/pm_err_regs_tb.sv
module pm_err_regs_tb;
    logic       clk = 0, rst = 1;
    logic       poll_mode = 0, mf_aligned = 0;
    logic       fas_err = 0, crc_err = 0, ebit_err = 0, sec_tick = 0;
    logic       rd_en = 0;
    logic [1:0] rd_addr = 0;
    logic [7:0] rd_data;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    int        m_cnt [2], m_snap [2], m_hold [2], m_ev [2], m_v, m_k;
    bit        m_clr [2];
    logic [7:0] exp_rd;

    always #2 clk = ~clk;

    pm_err_regs u_dut (
        .clk(clk), .rst(rst), .poll_mode(poll_mode), .mf_aligned(mf_aligned),
        .fas_err(fas_err), .crc_err(crc_err), .ebit_err(ebit_err),
        .sec_tick(sec_tick), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_snap[k] = 0; m_hold[k] = 0;
            end
            exp_rd = 8'h80;
        end else begin
            m_ev[0] = mf_aligned ? int'(crc_err) : int'(fas_err);
            m_ev[1] = (mf_aligned && ebit_err) ? 1 : 0;
            m_clr[0] = 0; m_clr[1] = 0;
            if (rd_en) begin
                m_k = rd_addr / 2;
                if (rd_addr % 2 == 0) begin
                    m_v = poll_mode ? m_cnt[m_k] : m_snap[m_k];
                    exp_rd = 8'(128 + m_v % 128);
                    m_hold[m_k] = m_v / 128;
                    if (poll_mode) m_clr[m_k] = 1;
                end else begin
                    exp_rd = 8'(128 + m_hold[m_k]);
                end
            end
            if (!poll_mode && sec_tick) begin
                for (int k = 0; k < 2; k++) begin
                    m_snap[k] = m_cnt[k]; m_clr[k] = 1;
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (m_clr[k]) m_cnt[k] = 0;
                if (m_ev[k] != 0 && m_cnt[k] < 16383) m_cnt[k]++;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (rd_data !== exp_rd) begin
                n_fail++;
                $display("FAIL %s per-cycle: rd_data=%h expected=%h", cur_req, rd_data, exp_rd);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0;
        chk(tag, rd_data, exp);
    endtask

    task automatic pulse(input int n, input bit f, input bit c, input bit e);
        repeat (n) begin
            @(negedge clk); fas_err = f; crc_err = c; ebit_err = e;
        end
        @(negedge clk); fas_err = 0; crc_err = 0; ebit_err = 0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        cur_req = "R1";
        chk("R1 idle data", rd_data, 8'h80);
        rd(0, 8'h80, "R1 fault low");
        rd(1, 8'h80, "R1 fault high");
        rd(2, 8'h80, "R1 far-end low");
        rd(3, 8'h80, "R1 far-end high");

        // R3/R4 snapshot mode, no multiframe alignment
        cur_req = "R3";
        pulse(5, 1, 0, 0);
        pulse(3, 0, 1, 0);
        pulse(2, 0, 0, 1);
        tick();
        rd(0, 8'h85, "R3 FAS errors counted, CRC ignored");
        rd(2, 8'h80, "R4 E bits ignored without alignment");
        rd(1, 8'h80, "R8 high half zero");

        // multiframe aligned: CRC and E bits counted
        mf_aligned = 1;
        pulse(200, 0, 1, 0);
        pulse(4, 1, 0, 0);
        pulse(9, 0, 0, 1);
        tick();
        rd(0, 8'hC8, "R2 low bits of 200");
        rd(1, 8'h81, "R8 high bits of 200");
        rd(2, 8'h89, "R4 E bits counted when aligned");
        rd(3, 8'h80, "R2 far-end high");
        cur_req = "R6";
        rd(0, 8'hC8, "R6 repeat read unchanged");

        // R5: event in tick cycle starts the new period
        cur_req = "R5";
        @(negedge clk); sec_tick = 1; crc_err = 1;
        @(negedge clk); sec_tick = 0; crc_err = 0;
        tick();
        rd(0, 8'h81, "R5 tick-cycle event in next period");
        rd(2, 8'h80, "R5 far-end restarted");

        // R7: polling mode
        cur_req = "R7";
        @(negedge clk); poll_mode = 1; mf_aligned = 0;
        pulse(3, 1, 0, 0);
        tick();
        pulse(2, 1, 0, 0);
        rd(0, 8'h85, "R7 live count, tick ignored");
        rd(0, 8'h80, "R7 cleared by read");
        @(negedge clk); rd_en = 1; rd_addr = 0; fas_err = 1;
        @(negedge clk); rd_en = 0; fas_err = 0;
        chk("R7 read with event returns old", rd_data, 8'h80);
        rd(0, 8'h81, "R7 event in read cycle kept");

        // R8: high half frozen at low read
        cur_req = "R8";
        mf_aligned = 1;
        pulse(130, 0, 1, 0);
        rd(0, 8'h82, "R8 low of 130");
        pulse(200, 0, 1, 0);
        rd(1, 8'h81, "R8 high frozen from low read");
        rd(0, 8'hC8, "R7 new period count");

        // R9: saturation
        cur_req = "R9";
        pulse(16400, 0, 1, 0);
        rd(0, 8'hFF, "R9 saturated low");
        rd(1, 8'hFF, "R9 saturated high");
        rd(0, 8'h80, "R9 cleared after saturation");

        // R10: data holds without reads
        cur_req = "R10";
        pulse(3, 0, 1, 0);
        repeat (4) @(negedge clk);
        chk("R10 read data held", rd_data, 8'h80);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule